// File: doc/BRIEF.md
# Double-Buffered Incremental Surface Evaluator

This block produces the value of a bivariate polynomial at consecutive raster positions using additions only. In quadratic mode it evaluates f(x,y) = A·x² + B·y² + C·x·y + D·x + E·y + F. In linear mode it evaluates f(x,y) = A·x + B·y + C. Here y counts line starts since the patch opened, starting at 0, and x counts pixel steps since the last line start. The host does not load the polynomial coefficients directly. It loads forward differences of them: a starting value, first differences and second differences for both directions. These values are held in two coefficient banks. The host always writes the bank that is not in use, and a swap command exchanges the two banks at a patch boundary.

All arithmetic is 48 bits wide, modulo 2^48. Each 48-bit accumulator is split into two 24-bit halves. The lower half adds in the cycle the strobe is taken, and the upper half adds one cycle later, using the carry that was saved. A synchronization register joins the two halves into one registered output word, which is flagged valid for one cycle per accepted strobe.

Top module: `fd_quad_eval`

## Requirements
- R1: After reset, out_valid and out_value are 0, bank 0 is the bank in use, and no patch is open.
- R2: A host write (wr_en) always goes to the bank not in use. Addresses 0..5 hold the words: 0 start value f(0,0); 1 first line difference; 2 second line difference; 3 first pixel difference; 4 per-line change of the pixel difference; 5 second pixel difference. Address 6 bit 0 is the mode: 1 selects linear, 0 selects quadratic. Writes never alter the values produced by an open patch.
- R3: A swap_req made while no patch is open takes effect at that clock edge. It opens a patch that uses the newly loaded bank.
- R4: A swap_req made while a patch is open is held. The held swap takes effect at the edge where patch_end is sampled, and a new patch opens at once.
- R5: The first line_start of a patch yields f(0,0). Each later line_start yields f(0,y) for the next y.
- R6: Each pix_step yields f(x+1,y) for the current line. When line_start and pix_step arrive in the same cycle, line_start wins.
- R7: In quadratic mode every result equals the polynomial modulo 2^48, including when carries or borrows cross bit 24 on strobes in consecutive cycles.
- R8: In linear mode words 2, 4 and 5 are ignored. The result is A·x+B·y+C taken modulo 2^24 and sign-extended to 48 bits.
- R9: A strobe sampled at clock edge k gives out_valid high for exactly the cycle after edge k+2. Strobes in every cycle give results in every cycle.
- R10: No output is produced for a strobe outside an open patch, for a pix_step before the first line_start of a patch, or for a strobe sampled together with patch_end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe into the bank not in use |
| wr_addr | input | 3 | Word address 0..5, or 6 for the mode bit |
| wr_data | input | 48 | Host write data |
| swap_req | input | 1 | Request to exchange the banks and open a patch |
| line_start | input | 1 | Advance to the start of the next line |
| pix_step | input | 1 | Advance one pixel along the line |
| patch_end | input | 1 | Close the current patch |
| out_valid | output | 1 | Result valid for this cycle |
| out_value | output | 48 | Function value at the current position |

## Verification
The hardest situation to reach is a swap that has been held. It needs a patch that is open and part way through a line, host writes going into the idle bank, and a swap request, all before patch_end finally releases the swap. The bench builds this sequence step by step. It checks that the remaining pixels still come from the first coefficient set and that the very next line start uses the second set. Carries between the two halves are forced by coefficients close to 2^24, including negative ones, with strobes arriving in every cycle. Strobes that land on patch_end, or before the first line of a patch, are driven on purpose to show that no output results.

// File: rtl/fd_eval_pkg.sv
package fd_eval_pkg;
  // raster operation taken in a cycle
  typedef enum logic [1:0] {OP_NONE, OP_LOAD, OP_LINE, OP_PIX} fd_op_e;
  // per-half accumulator command
  typedef enum logic [1:0] {LN_HOLD, LN_LOAD, LN_ADD} lane_op_e;

  localparam int NUM_WORDS = 6;
  localparam int W_ROW0  = 0;  // f(0,0)
  localparam int W_DY0   = 1;  // first line difference
  localparam int W_DDY   = 2;  // second line difference
  localparam int W_DX0   = 3;  // first pixel difference
  localparam int W_DXROW = 4;  // per-line change of pixel difference
  localparam int W_DDX   = 5;  // second pixel difference

  localparam int NUM_LANES = 5;
  localparam int L_RV  = 0;    // line start value
  localparam int L_RDY = 1;    // line difference
  localparam int L_RDX = 2;    // pixel difference at x = 0
  localparam int L_CV  = 3;    // current value
  localparam int L_CDX = 4;    // current pixel difference
endpackage

// File: rtl/fd_coef_banks.sv
module fd_coef_banks
  import fd_eval_pkg::*;
#(
  parameter int W  = 48,
  parameter int NW = NUM_WORDS,
  parameter int AW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [W-1:0]         wr_data,
  output logic [NW-1:0][W-1:0] rd_words,
  output logic                 rd_lin
);
  logic [NW-1:0][W-1:0] bank_words [2];
  logic                 bank_lin   [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [NW-1:0][W-1:0] words_q;
    logic                 lin_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        words_q <= '0;
        lin_q   <= 1'b0;
      end else if (wr_en && (sel != 1'(g))) begin
        if (wr_addr < AW'(NW))
          words_q[wr_addr] <= wr_data;
        else if (wr_addr == AW'(NW))
          lin_q <= wr_data[0];
      end
    end
    assign bank_words[g] = words_q;
    assign bank_lin[g]   = lin_q;
  end

  assign rd_words = bank_words[sel];
  assign rd_lin   = bank_lin[sel];

  // R2: the bank in use only changes content across a swap
  a_r2_active_bank_steady: assert property (@(posedge clk) disable iff (rst)
    $stable(sel) |-> ($stable(rd_words) && $stable(rd_lin)));
endmodule

// File: rtl/fd_split_lane.sv
module fd_split_lane
  import fd_eval_pkg::*;
#(
  parameter int HALF_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  lane_op_e              op_lo,
  input  lane_op_e              op_hi,
  input  logic [HALF_W-1:0]     ld_lo,
  input  logic [HALF_W-1:0]     ld_hi,
  input  logic [HALF_W-1:0]     a_lo,
  input  logic [HALF_W-1:0]     b_lo,
  input  logic [HALF_W-1:0]     a_hi,
  input  logic [HALF_W-1:0]     b_hi,
  output logic [2*HALF_W-1:0]   q
);
  logic [HALF_W-1:0] lo_q, hi_q, hi_nxt;
  logic              cy_q;
  logic [HALF_W:0]   lo_sum;

  assign lo_sum = {1'b0, a_lo} + {1'b0, b_lo};

  always_comb begin
    case (op_hi)
      LN_LOAD: hi_nxt = ld_hi;
      LN_ADD:  hi_nxt = a_hi + b_hi + {{(HALF_W-1){1'b0}}, cy_q};
      default: hi_nxt = hi_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
      cy_q <= 1'b0;
    end else begin
      hi_q <= hi_nxt;
      case (op_lo)
        LN_LOAD: begin
          lo_q <= ld_lo;
          cy_q <= 1'b0;
        end
        LN_ADD:  {cy_q, lo_q} <= lo_sum;
        default: ;
      endcase
    end
  end

  assign q = {hi_q, lo_q};

  // R7: with neither half busy the accumulator keeps its value
  a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (op_lo == LN_HOLD && op_hi == LN_HOLD) |=> $stable(q));
endmodule

// File: rtl/fd_patch_ctrl.sv
module fd_patch_ctrl
  import fd_eval_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   swap_req,
  input  logic   patch_end,
  input  logic   line_start,
  input  logic   pix_step,
  output logic   bank_sel,
  output fd_op_e op
);
  logic open_q, first_q, pend_q, take;

  assign take = (swap_req || pend_q) && (!open_q || patch_end);

  always_comb begin
    op = OP_NONE;
    if (open_q && !patch_end) begin
      if (line_start)
        op = first_q ? OP_LOAD : OP_LINE;
      else if (pix_step && !first_q)
        op = OP_PIX;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_sel <= 1'b0;
      open_q   <= 1'b0;
      first_q  <= 1'b0;
      pend_q   <= 1'b0;
    end else if (take) begin
      bank_sel <= ~bank_sel;
      open_q   <= 1'b1;
      first_q  <= 1'b1;
      pend_q   <= 1'b0;
    end else begin
      if (patch_end)
        open_q <= 1'b0;
      else if (swap_req && open_q)
        pend_q <= 1'b1;
      if (op == OP_LOAD)
        first_q <= 1'b0;
    end
  end

  // R4: no bank exchange while a patch runs
  a_r4_sel_stable_in_patch: assert property (@(posedge clk) disable iff (rst)
    (open_q && !patch_end) |=> $stable(bank_sel));
  // R4: a held request exists only inside a patch
  a_r4_pend_only_open: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> open_q);
  // R3: an idle swap flips the bank and opens a patch
  a_r3_idle_swap: assert property (@(posedge clk) disable iff (rst)
    (!open_q && swap_req) |=> (bank_sel != $past(bank_sel)) && open_q);
endmodule

// File: rtl/fd_quad_eval.sv
module fd_quad_eval
  import fd_eval_pkg::*;
#(
  parameter int HALF_W = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [2:0]              wr_addr,
  input  logic [2*HALF_W-1:0]     wr_data,
  input  logic                    swap_req,
  input  logic                    line_start,
  input  logic                    pix_step,
  input  logic                    patch_end,
  output logic                    out_valid,
  output logic [2*HALF_W-1:0]     out_value
);
  localparam int W  = 2 * HALF_W;
  localparam int NW = NUM_WORDS;
  localparam int AW = $clog2(NW + 1);

  logic                 bank_sel, rd_lin;
  logic [NW-1:0][W-1:0] rd_words;
  fd_op_e               op, op_d_q;

  fd_coef_banks #(.W(W), .NW(NW), .AW(AW)) u_banks (
    .clk(clk), .rst(rst), .sel(bank_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_words(rd_words), .rd_lin(rd_lin)
  );

  fd_patch_ctrl u_ctrl (
    .clk(clk), .rst(rst), .swap_req(swap_req), .patch_end(patch_end),
    .line_start(line_start), .pix_step(pix_step),
    .bank_sel(bank_sel), .op(op)
  );

  // second differences vanish in linear mode
  logic [W-1:0] ddy_e, dxrow_e, ddx_e;
  assign ddy_e   = rd_lin ? '0 : rd_words[W_DDY];
  assign dxrow_e = rd_lin ? '0 : rd_words[W_DXROW];
  assign ddx_e   = rd_lin ? '0 : rd_words[W_DDX];

  logic [W-1:0]      lane_q [NUM_LANES];
  lane_op_e          cmd_lo [NUM_LANES], cmd_hi [NUM_LANES];
  logic [HALF_W-1:0] a_lo [NUM_LANES], b_lo [NUM_LANES], ld_lo [NUM_LANES];
  logic [HALF_W-1:0] a_hi [NUM_LANES], b_hi [NUM_LANES], ld_hi [NUM_LANES];

  // operand routing: stage 0 follows this cycle's op, stage 1 the previous one
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      fd_op_e       o;
      lane_op_e     c;
      logic [W-1:0] a, b, ld;
      o = (s == 0) ? op : op_d_q;
      for (int ln = 0; ln < NUM_LANES; ln++) begin
        case (ln)
          L_RV:  begin a = lane_q[L_RV];  b = lane_q[L_RDY]; ld = rd_words[W_ROW0]; end
          L_RDY: begin a = lane_q[L_RDY]; b = ddy_e;         ld = rd_words[W_DY0];  end
          L_RDX: begin a = lane_q[L_RDX]; b = dxrow_e;       ld = rd_words[W_DX0];  end
          L_CV: begin
            a  = (o == OP_PIX) ? lane_q[L_CV]  : lane_q[L_RV];
            b  = (o == OP_PIX) ? lane_q[L_CDX] : lane_q[L_RDY];
            ld = rd_words[W_ROW0];
          end
          default: begin
            a  = (o == OP_PIX) ? lane_q[L_CDX] : lane_q[L_RDX];
            b  = (o == OP_PIX) ? ddx_e         : dxrow_e;
            ld = rd_words[W_DX0];
          end
        endcase
        case (o)
          OP_LOAD: c = LN_LOAD;
          OP_LINE: c = LN_ADD;
          OP_PIX:  c = (ln >= L_CV) ? LN_ADD : LN_HOLD;
          default: c = LN_HOLD;
        endcase
        if (s == 0) begin
          cmd_lo[ln] = c;
          a_lo[ln]   = a[HALF_W-1:0];
          b_lo[ln]   = b[HALF_W-1:0];
          ld_lo[ln]  = ld[HALF_W-1:0];
        end else begin
          cmd_hi[ln] = c;
          a_hi[ln]   = a[W-1:HALF_W];
          b_hi[ln]   = b[W-1:HALF_W];
          ld_hi[ln]  = ld[W-1:HALF_W];
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    fd_split_lane #(.HALF_W(HALF_W)) u_lane (
      .clk(clk), .rst(rst),
      .op_lo(cmd_lo[g]), .op_hi(cmd_hi[g]),
      .ld_lo(ld_lo[g]), .ld_hi(ld_hi[g]),
      .a_lo(a_lo[g]), .b_lo(b_lo[g]),
      .a_hi(a_hi[g]), .b_hi(b_hi[g]),
      .q(lane_q[g])
    );
  end

  // alignment: hold the lower half while the upper half finishes
  logic [HALF_W-1:0] lo_hold_q;
  logic              s1_valid_q, s1_lin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_d_q     <= OP_NONE;
      lo_hold_q  <= '0;
      s1_valid_q <= 1'b0;
      s1_lin_q   <= 1'b0;
      out_valid  <= 1'b0;
      out_value  <= '0;
    end else begin
      op_d_q     <= op;
      s1_valid_q <= (op_d_q != OP_NONE);
      s1_lin_q   <= rd_lin;
      if (op_d_q != OP_NONE)
        lo_hold_q <= lane_q[L_CV][HALF_W-1:0];
      out_valid <= s1_valid_q;
      if (s1_valid_q)
        out_value <= s1_lin_q ? {{HALF_W{lo_hold_q[HALF_W-1]}}, lo_hold_q}
                              : {lane_q[L_CV][W-1:HALF_W], lo_hold_q};
    end
  end

  // R9: every accepted strobe yields a result three edges later
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (op != OP_NONE) |=> ##2 out_valid);
  // R9 / R10: no result without an accepted strobe
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(op, 3) != OP_NONE));
  // R8: linear results are sign-extended 24-bit values
  a_r8_linear_sext: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(rd_lin, 2)) |-> (out_value[W-1:HALF_W] == {HALF_W{out_value[HALF_W-1]}}));
endmodule

// File: tb/test_fd_quad_eval.sv
module test_fd_quad_eval;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [47:0] wr_data = '0;
  logic        swap_req = 1'b0, line_start = 1'b0, pix_step = 1'b0, patch_end = 1'b0;
  logic        out_valid;
  logic [47:0] out_value;

  int tests_run = 0, tests_failed = 0;
  bit done = 1'b0;
  logic [47:0] cap [0:255];
  int cap_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fd_quad_eval #(.HALF_W(24)) i_fd_quad_eval (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .swap_req(swap_req), .line_start(line_start), .pix_step(pix_step),
    .patch_end(patch_end), .out_valid(out_valid), .out_value(out_value)
  );

  always @(negedge clk) if (out_valid && cap_n < 256) begin
    cap[cap_n] = out_value;
    cap_n++;
  end

  task automatic chk(string req, logic [47:0] got, logic [47:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [47:0] fq(longint a, longint b, longint c, longint d,
                                     longint e, longint f, longint x, longint y);
    longint v;
    v = a*x*x + b*y*y + c*x*y + d*x + e*y + f;
    return v[47:0];
  endfunction

  function automatic logic [47:0] fl(longint a, longint b, longint c, longint x, longint y);
    longint v;
    logic [23:0] t;
    v = a*x + b*y + c;
    t = v[23:0];
    return {{24{t[23]}}, t};
  endfunction

  task automatic load_words(longint w0, longint w1, longint w2, longint w3,
                            longint w4, longint w5, bit lin);
    longint w [7];
    w = '{w0, w1, w2, w3, w4, w5, longint'(lin)};
    for (int i = 0; i < 7; i++) begin
      longint v;
      v = w[i];
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(i); wr_data = v[47:0];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_quad(longint a, longint b, longint c, longint d, longint e, longint f);
    load_words(f, b + e, 2*b, a + d, c, 2*a, 1'b0);
  endtask

  task automatic pulse_swap();
    @(negedge clk); swap_req = 1'b1;
    @(negedge clk); swap_req = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); patch_end = 1'b1;
    @(negedge clk); patch_end = 1'b0;
  endtask

  task automatic strobe(bit l, bit p);
    @(negedge clk); line_start = l; pix_step = p;
    @(negedge clk); line_start = 1'b0; pix_step = 1'b0;
  endtask

  // strobes in every cycle: line_start then pix steps, for each line
  task automatic stream(int lines, int pix);
    for (int y = 0; y < lines; y++) begin
      @(negedge clk); line_start = 1'b1; pix_step = 1'b0;
      for (int x = 0; x < pix; x++) begin
        @(negedge clk); line_start = 1'b0; pix_step = 1'b1;
      end
    end
    @(negedge clk); line_start = 1'b0; pix_step = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", 48'(out_valid), 48'd0);
    chk("R1 out_value", out_value, 48'd0);
  endtask

  task automatic t_idle_ignored();
    cap_n = 0;
    strobe(1'b1, 1'b0); strobe(1'b0, 1'b1); strobe(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    chk("R10 no output without patch", 48'(cap_n), 48'd0);
  endtask

  task automatic t_quad(longint a, longint b, longint c, longint d, longint e, longint f, string tag);
    load_quad(a, b, c, d, e, f);
    pulse_swap();                       // R3: idle swap opens patch
    cap_n = 0;
    stream(4, 5);
    pulse_end();
    chk({tag, " R5 count"}, 48'(cap_n), 48'd24);
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 6; x++)
        chk({tag, " R7 R6 value"}, cap[y*6 + x], fq(a, b, c, d, e, f, x, y));
  endtask

  task automatic t_latency();
    load_quad(1, 2, 3, 4, 5, 'h123);
    pulse_swap();
    cap_n = 0;
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    chk("R9 not yet (1)", 48'(out_valid), 48'd0);
    @(negedge clk);
    chk("R9 not yet (2)", 48'(out_valid), 48'd0);
    @(negedge clk);
    chk("R9 valid", 48'(out_valid), 48'd1);
    chk("R5 first value", out_value, 48'h123);
    @(negedge clk);
    chk("R9 single pulse", 48'(out_valid), 48'd0);
    pulse_end();
  endtask

  task automatic t_linear();
    longint a = 'h400000, b = -3, c = 'h7FFFF0;
    load_words(c, b, 'h123456789, a, 'h55AA55, 'h0F0F0F0F, 1'b1);
    pulse_swap();
    cap_n = 0;
    stream(3, 4);
    pulse_end();
    chk("R8 count", 48'(cap_n), 48'd15);
    for (int y = 0; y < 3; y++)
      for (int x = 0; x < 5; x++)
        chk("R8 linear value", cap[y*5 + x], fl(a, b, c, x, y));
  endtask

  task automatic t_swap_held();
    logic [47:0] exp [8];
    load_quad(2, 3, -4, 'hFFFFF, 6, 'hFFFFFE);
    pulse_swap();
    cap_n = 0;
    strobe(1'b1, 1'b0); strobe(1'b0, 1'b1); strobe(1'b0, 1'b1);
    load_quad(-5, 1, 7, 9, -2, 'h777);     // R2: into idle bank during patch
    pulse_swap();                          // R4: must be held
    strobe(1'b0, 1'b1); strobe(1'b0, 1'b1); strobe(1'b1, 1'b0);
    pulse_end();
    strobe(1'b1, 1'b0); strobe(1'b0, 1'b1);
    repeat (4) @(negedge clk);
    exp = '{fq(2,3,-4,'hFFFFF,6,'hFFFFFE,0,0), fq(2,3,-4,'hFFFFF,6,'hFFFFFE,1,0),
            fq(2,3,-4,'hFFFFF,6,'hFFFFFE,2,0), fq(2,3,-4,'hFFFFF,6,'hFFFFFE,3,0),
            fq(2,3,-4,'hFFFFF,6,'hFFFFFE,4,0), fq(2,3,-4,'hFFFFF,6,'hFFFFFE,0,1),
            fq(-5,1,7,9,-2,'h777,0,0),         fq(-5,1,7,9,-2,'h777,1,0)};
    chk("R4 count", 48'(cap_n), 48'd8);
    for (int i = 0; i < 8; i++)
      chk("R4 R2 held swap value", cap[i], exp[i]);
    pulse_end();
  endtask

  task automatic t_ignored_in_patch();
    load_quad(4, -1, 2, 'h10, 3, 'h40);
    pulse_swap();
    cap_n = 0;
    strobe(1'b0, 1'b1);                    // R10: pixel before first line
    strobe(1'b1, 1'b0);
    strobe(1'b0, 1'b1);
    strobe(1'b1, 1'b1);                    // R6: line_start wins
    strobe(1'b0, 1'b1);
    @(negedge clk); patch_end = 1'b1; line_start = 1'b1;   // R10: dropped
    @(negedge clk); patch_end = 1'b0; line_start = 1'b0;
    strobe(1'b1, 1'b0);                    // R10: patch closed
    repeat (4) @(negedge clk);
    chk("R10 count", 48'(cap_n), 48'd4);
    chk("R10 first line", cap[0], fq(4,-1,2,'h10,3,'h40,0,0));
    chk("R6 pixel", cap[1], fq(4,-1,2,'h10,3,'h40,1,0));
    chk("R6 priority", cap[2], fq(4,-1,2,'h10,3,'h40,0,1));
    chk("R6 pixel after priority", cap[3], fq(4,-1,2,'h10,3,'h40,1,1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle_ignored();
    t_quad(3, -2, 5, 'h7FFFF0, -11, 'hFFFFF0, "pos");
    t_quad(-7, 9, -13, -'h800001, 'h3FFFFF, 5, "neg");
    t_latency();
    t_linear();
    t_swap_held();
    t_ignored_in_patch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule